// File: doc/BRIEF.md
# Infrared SIR Pulse Codec

This block sits between the serial pins of a UART and an infrared line transceiver. On the send side it turns each bit cell of the UART's transmit stream into either one short light pulse or no pulse. A zero bit, the start bit included, becomes a pulse three sample ticks wide placed in the middle of the cell. A one bit, the stop bit included, leaves the emitter dark for the whole cell. On the receive side it turns each detected pulse back into a low bit that lasts a full cell, so an ordinary 16x-oversampling UART receiver can sample the recovered stream without knowing the link is optical.

The codec runs on the system clock. It advances only on the same 16x sample tick that drives the UART, so it covers every bit rate the UART's divider can produce, up to the 115.2 kbit/s ceiling of the slow infrared mode. An enable input selects the infrared coding. With the enable low, both directions pass the plain serial levels straight through. The transmit bit cell follows the UART data: the cell phase restarts whenever the transmit level changes. The receive input passes through a synchronizer, and the decoder checks it only on ticks, which filters short glitches.

Top module: `irsir_codec`

## Requirements
- R1: With `ir_en` high, a zero on `uart_txd` drives `ir_txd` high for exactly PULSE_LEN (3) ticks. The pulse starts PULSE_START (7) ticks after the tick that first samples the zero. A run of zeros gives one such pulse every SAMPLES (16) ticks.
- R2: With `ir_en` high, a one on `uart_txd`, and the idle line, keep `ir_txd` low for the whole cell.
- R3: The transmit cell phase restarts at the first tick that sees a change of `uart_txd`, so pulses stay in the same place in every cell of every frame, whatever the phase was when the line was idle.
- R4: With `ir_en` high, `ir_rxd` is active high and passes through two synchronizer flops. `uart_rxd` falls at the tick where a pulse is first seen, which is one tick after a pulse raised just after a tick. It stays low for the longer of SAMPLES ticks and the number of ticks at which the pulse is seen.
- R5: With `ir_en` high, an `ir_rxd` pulse that is not present, after synchronization, at any tick leaves `uart_rxd` high.
- R6: With `ir_en` low, `ir_txd` equals `uart_txd` delayed by one clock.
- R7: With `ir_en` low, `uart_rxd` equals `ir_rxd` delayed by three clocks (two synchronizer flops plus the output register).
- R8: While `rst` is high, `ir_txd` is 0 and `uart_rxd` is 1.
- R9: Two pulses that start SAMPLES ticks apart give one unbroken low on `uart_rxd` lasting two cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | One-clock strobe at 16 times the bit rate |
| ir_en | input | 1 | 1 selects infrared coding, 0 selects pass-through |
| uart_txd | input | 1 | Serial transmit data from the UART |
| uart_rxd | output | 1 | Recovered serial receive data to the UART |
| ir_txd | output | 1 | Emitter drive, active high |
| ir_rxd | input | 1 | Detector output, active high, asynchronous |

## Verification
Two situations are hard to reach from the ports. The first is a receive pulse that lasts longer than a cell, so the hold counter has already run out while the input is still high. The second is a short glitch that falls entirely between two ticks once it has passed the synchronizer. The bench locks onto the tick phase before each stimulus. It then sweeps pulse widths from one tick to well past a cell, and places one- to three-clock glitches at an offset where the delayed copy misses the next tick. On the transmit side, whole frames are sent after idle gaps of varying phase. Every cell is compared with a waveform computed from the bit value and the tick offset.

// File: rtl/irsir_pkg.sv
package irsir_pkg;
  // True when a cell phase lies inside the pulse window [start, start+len).
  function automatic logic in_slot(input int unsigned ph, input int unsigned start,
                                   input int unsigned len);
    return (ph >= start) && (ph < start + len);
  endfunction
endpackage

// File: rtl/irsir_sync.sv
module irsir_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irsir_tx_enc.sv
module irsir_tx_enc
  import irsir_pkg::*;
#(
  parameter int SAMPLES     = 16,
  parameter int PULSE_START = 7,
  parameter int PULSE_LEN   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic ir_en,
  input  logic txd,
  output logic ir_txd
);
  localparam int PW = $clog2(SAMPLES);
  localparam logic [PW-1:0] LAST = PW'(SAMPLES - 1);

  logic [PW-1:0] phase, phase_nx;
  logic          txd_q, pulse_nx, out_q;

  // Cell phase restarts on any level change, otherwise wraps every cell
  always_comb begin
    if ((txd != txd_q) || (phase == LAST)) phase_nx = '0;
    else                                   phase_nx = phase + 1'b1;
    pulse_nx = !txd && in_slot(32'(phase_nx), PULSE_START, PULSE_LEN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= LAST;
      txd_q <= 1'b1;
      out_q <= 1'b0;
    end else begin
      if (tick) begin
        phase <= phase_nx;
        txd_q <= txd;
      end
      if (!ir_en)    out_q <= txd;
      else if (tick) out_q <= pulse_nx;
    end
  end

  assign ir_txd = out_q;

  // Checker: ticks spent with the emitter on in the current pulse
  logic [PW:0] run;
  always_ff @(posedge clk) begin
    if (rst || !ir_en || !out_q) run <= '0;
    else if (tick)               run <= run + 1'b1;
  end

  // R1
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    run <= (PW+1)'(PULSE_LEN));

  // R1
  pulse_place_chk: assert property (@(posedge clk) disable iff (rst)
    ir_en && $past(ir_en) && $rose(out_q) |-> (phase == PW'(PULSE_START)) && !txd_q);
endmodule

// File: rtl/irsir_rx_dec.sv
module irsir_rx_dec #(
  parameter int SAMPLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic ir_en,
  input  logic rx_s,
  output logic rxd
);
  localparam int PW = $clog2(SAMPLES);
  localparam logic [PW-1:0] LAST = PW'(SAMPLES - 1);

  logic [PW-1:0] cnt;
  logic          seen_q, out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      seen_q <= 1'b0;
      out_q  <= 1'b1;
    end else if (!ir_en) begin
      cnt    <= '0;
      seen_q <= 1'b0;
      out_q  <= rx_s;
    end else if (tick) begin
      seen_q <= rx_s;
      if (rx_s) begin
        out_q <= 1'b0;
        if (!seen_q)         cnt <= LAST;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
      end else if (cnt != '0) begin
        out_q <= 1'b0;
        cnt   <= cnt - 1'b1;
      end else begin
        out_q <= 1'b1;
      end
    end
  end

  assign rxd = out_q;

  // R4
  fall_on_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ir_en && $past(ir_en) && $fell(out_q) |-> $past(rx_s));

  // R4
  rise_after_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ir_en && $past(ir_en) && $rose(out_q) |-> !$past(rx_s) && ($past(cnt) == '0));
endmodule

// File: rtl/irsir_codec.sv
module irsir_codec #(
  parameter int SAMPLES     = 16,
  parameter int PULSE_START = 7,
  parameter int PULSE_LEN   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick16,
  input  logic ir_en,
  input  logic uart_txd,
  output logic uart_rxd,
  output logic ir_txd,
  input  logic ir_rxd
);
  logic rx_s;

  irsir_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
    .clk(clk), .rst(rst), .d(ir_rxd), .q(rx_s)
  );

  irsir_tx_enc #(.SAMPLES(SAMPLES), .PULSE_START(PULSE_START), .PULSE_LEN(PULSE_LEN)) u_enc (
    .clk(clk), .rst(rst), .tick(tick16), .ir_en(ir_en), .txd(uart_txd), .ir_txd(ir_txd)
  );

  irsir_rx_dec #(.SAMPLES(SAMPLES)) u_dec (
    .clk(clk), .rst(rst), .tick(tick16), .ir_en(ir_en), .rx_s(rx_s), .rxd(uart_rxd)
  );

  // R6
  bypass_tx_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !ir_en && !$past(ir_en) |-> ir_txd == $past(uart_txd));
endmodule

// File: tb/irsir_codec_test.sv
module irsir_codec_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ir_en = 1'b1;
  logic uart_txd = 1'b1;
  logic ir_rxd = 1'b0;
  logic uart_rxd, ir_txd, tick16;
  logic [1:0] div = 2'd0;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;
  always_ff @(posedge clk) div <= div + 2'd1;
  assign tick16 = (div == 2'd3);

  irsir_codec uut (
    .clk(clk), .rst(rst), .tick16(tick16), .ir_en(ir_en), .uart_txd(uart_txd),
    .uart_rxd(uart_rxd), .ir_txd(ir_txd), .ir_rxd(ir_rxd)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Leaves the bench at the negedge right after a clock edge that carried a tick
  task automatic sync_tick();
    do @(negedge clk); while (div != 2'd3);
    @(negedge clk);
  endtask

  // One 10-bit frame; every cell compared against the computed pulse waveform
  task automatic send_frame(input logic [7:0] d);
    logic [9:0]  fr;
    logic [10:0] bad;
    fr = {1'b1, d, 1'b0};
    bad = '0;
    sync_tick();
    for (int c = 0; c < 708; c++) begin
      if (c >= 4) begin
        int n, b, off;
        logic ex;
        n = c - 4; b = n / 64; off = n % 64;
        ex = (b < 10) && !fr[b] && (off >= 28) && (off < 40);
        if (ir_txd !== ex) bad[b] = 1'b1;
      end
      if ((c % 64 == 0) && (c < 640)) uart_txd = fr[c / 64];
      if (c == 640) uart_txd = 1'b1;
      @(negedge clk);
    end
    for (int b = 0; b < 11; b++) begin
      if (b < 10 && !fr[b]) check(!bad[b], "R1 R3 zero cell", int'(bad[b]), 0);
      else                  check(!bad[b], "R2 one/idle cell", int'(bad[b]), 0);
    end
  endtask

  // Pulse of k ticks (optional second one a cell later); measure the decoded low
  task automatic rx_pulse(input int k, input logic twice, input int exp_low, input string req);
    int lows, first, rises;
    logic prev;
    lows = 0; first = -1; rises = 0; prev = 1'b1;
    sync_tick();
    for (int c = 0; c < 720; c++) begin
      if (!uart_rxd) begin
        lows++;
        if (first < 0) first = c;
      end
      if (uart_rxd && !prev) rises++;
      prev = uart_rxd;
      if (c == 0) ir_rxd = 1'b1;
      if (c == 4 * k) ir_rxd = 1'b0;
      if (twice && c == 64) ir_rxd = 1'b1;
      if (twice && c == 64 + 4 * k) ir_rxd = 1'b0;
      @(negedge clk);
    end
    check(lows == exp_low, req, lows, exp_low);
    check(first == 4, "R4 fall latency", first, 4);
    check(rises == 1, "R9 single unbroken low", rises, 1);
  endtask

  task automatic rx_glitch(input int w);
    int lows;
    lows = 0;
    sync_tick();
    for (int c = 0; c < 100; c++) begin
      if (!uart_rxd) lows++;
      if (c == 2) ir_rxd = 1'b1;
      if (c == 2 + w) ir_rxd = 1'b0;
      @(negedge clk);
    end
    check(lows == 0, "R5 glitch ignored", lows, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R8: state held in reset
    check(ir_txd == 1'b0, "R8 ir_txd in reset", int'(ir_txd), 0);
    check(uart_rxd == 1'b1, "R8 uart_rxd in reset", int'(uart_rxd), 1);
    rst = 1'b0;
    repeat (7) @(negedge clk);

    // R1 R2 R3: frames over a spread of data bytes and idle phases
    for (int i = 0; i < 16; i++) begin
      logic [7:0] d;
      d = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'(i * 37 + 11);
      send_frame(d);
      repeat (i % 5) @(negedge clk);
    end

    // R4: pulse widths from one tick to well past a cell
    for (int k = 1; k <= 24; k++) begin
      rx_pulse(k, 1'b0, 4 * ((k > 16) ? k : 16), "R4 low length");
      repeat (8) @(negedge clk);
    end
    // R9: two pulses one cell apart
    rx_pulse(3, 1'b1, 128, "R9 back-to-back low length");
    // R5: glitches missing every tick
    for (int w = 1; w <= 3; w++) rx_glitch(w);

    // R6 R7: pass-through
    begin
      logic [3:0] rxh, txh;
      logic [7:0] lfsr;
      lfsr = 8'h5A; rxh = '0; txh = '0;
      @(negedge clk);
      ir_en = 1'b0;
      for (int i = 0; i < 60; i++) begin
        if (i >= 2) check(ir_txd == txh[0], "R6 tx bypass", int'(ir_txd), int'(txh[0]));
        if (i >= 4) check(uart_rxd == rxh[2], "R7 rx bypass", int'(uart_rxd), int'(rxh[2]));
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        uart_txd = lfsr[0];
        ir_rxd = lfsr[3];
        txh = {txh[2:0], lfsr[0]};
        rxh = {rxh[2:0], lfsr[3]};
        @(negedge clk);
      end
    end

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule